// File: doc/BRIEF.md
# Shared Address/Data Port with External Bus Sequencer

This block runs a 16-pin bidirectional port. In general-purpose mode, software owns the pins through a direction register and an output latch. When bus mode is enabled, a bus-cycle sequencer takes over the pins. It time-shares them between an address phase, a write-data phase and a released read phase. It also splits word transfers into two byte cycles when the external data bus is 8 bits wide. The pins are modelled as three vectors: a value driven out, an enable for each pin, and the value sampled back in.

The configuration is captured once, on the first clock edge after reset is released, from the high byte of the pins. Bits [1:0] of that byte select the bus mode. Until that edge, the pull-up request is active and every pin is released. Bus transfers enter as valid/ready requests. Results come back as a valid/ready response that the consumer can stall. While a response is stalled, no new request is accepted, so back-pressure reaches the requester through the request's ready signal.

Top module: `adport_ctrl`

## Requirements
- R1: While reset is asserted, `pullup_en` is 1 and `pad_oe` is all zeros. On the first clock edge after reset is released, `cfg_o` takes the value of `pad_i[15:8]` and `pullup_en` drops to 0. `cfg_o[1:0]` selects the bus mode: 00 is 8-bit demultiplexed, 01 is 8-bit multiplexed, 10 is 16-bit demultiplexed and 11 is 16-bit multiplexed.
- R2: In both multiplexed modes, each byte or word cycle starts with one address clock. In that clock all 16 pins drive the cycle's address with `pad_oe` = 16'hFFFF. One data clock follows.
- R3: In a read data clock, the bus-owned low lane is released (`pad_oe[7:0]` = 0). The pins are sampled at the clock edge that ends that data clock.
- R4: In a write data clock, the write data is driven. On an 8-bit bus this is the current byte on `pad_o[7:0]`. On a 16-bit bus it is the whole `req_wdata`, with every pin enabled.
- R5: On an 8-bit bus, a word transfer (`req_word` = 1) becomes two byte cycles. The first cycle handles the low byte at `req_addr`. The second handles the high byte at `req_addr`+1. A word read returns `{second byte, first byte}`.
- R6: In 8-bit multiplexed mode, `pad_o[15:8]` carries the cycle's address bits [15:8] and stays enabled through both clocks of each byte cycle.
- R7: Demultiplexed modes have no address clock. In 8-bit demultiplexed mode, the high lane stays under software control while bus mode is on.
- R8: `req_ready` is 1 only when `bus_en` is 1, the configuration has been captured, and the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are 1.
- R9: After the last data clock, `rsp_valid` rises. It stays high with `rsp_rdata` unchanged until a clock edge where `rsp_ready` is 1. Byte reads return the byte zero-extended. Writes return 0.
- R10: While bus mode is on, software latch writes to bus-owned lanes are discarded. Writes to lanes still under software control take effect.
- R11: With bus mode off, `pad_oe` equals the direction register and `pad_o` equals the latch. A direction value written while bus mode was on becomes active once bus mode is switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Hands the port to the bus sequencer |
| cfg_o | output | 8 | Pin configuration captured after reset |
| pullup_en | output | 1 | Pull-up request, high until configuration is captured |
| sw_dir_we | input | 1 | Software direction register write strobe |
| sw_dir_wd | input | 16 | Direction value, 1 = output |
| sw_out_we | input | 1 | Software output latch write strobe |
| sw_out_wd | input | 16 | Output latch value |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | 16 | Intra-segment address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Transfer finished |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data, zero for writes |
| pad_i | input | 16 | Sampled pin values |
| pad_o | output | 16 | Driven pin values |
| pad_oe | output | 16 | Per-pin output enable |

## Verification
The assertions assume that `bus_en` changes only while the sequencer is idle with no response pending. They also assume that the high byte of `pad_i` is stable at the clock edge that releases reset. The stimulus switches bus mode only after a response has been consumed. It loads the configuration byte on the pins before reset is released, and it changes the mode only by applying a new reset. Read data on the pins is set in the data clock that samples it, so the value sampled is always the one intended for that byte cycle.

// File: rtl/adport_pkg.sv
package adport_pkg;
  typedef enum logic [1:0] {
    MODE_DMX8  = 2'b00,
    MODE_MUX8  = 2'b01,
    MODE_DMX16 = 2'b10,
    MODE_MUX16 = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/adport_cfg.sv
module adport_cfg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] pad_hi,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o     <= '0;
      cfg_valid <= 1'b0;
    end else if (!cfg_valid) begin
      cfg_o     <= pad_hi;
      cfg_valid <= 1'b1;
    end
  end

  // R1: once captured, the configuration never changes until the next reset
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_valid && $stable(cfg_o)));
endmodule

// File: rtl/adport_seq.sv
module adport_seq
  import adport_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  bus_mode_e    mode,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_addr,
  input  logic         req_write,
  input  logic         req_word,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] alt_out,
  output logic [W-1:0] alt_oe,
  output phase_e       phase_o,
  output logic         write_o
);
  localparam int B = W / 2;

  phase_e       ph;
  logic [W-1:0] addr_q, wdata_q, rdata_q;
  logic         write_q, word_q, hi_q;
  logic         is8, mux;
  logic [W-1:0] cur_addr;
  logic [B-1:0] byte_sel;

  assign is8      = (mode == MODE_DMX8) || (mode == MODE_MUX8);
  assign mux      = (mode == MODE_MUX8) || (mode == MODE_MUX16);
  assign cur_addr = addr_q + W'(hi_q);
  assign byte_sel = hi_q ? wdata_q[W-1:B] : wdata_q[B-1:0];

  assign req_ready = active && (ph == PH_IDLE);
  assign rsp_valid = (ph == PH_DONE);
  assign rsp_rdata = rdata_q;
  assign phase_o   = ph;
  assign write_o   = write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (req_valid && req_ready) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          word_q  <= req_word;
          hi_q    <= 1'b0;
          rdata_q <= '0;
          ph      <= mux ? PH_ADDR : PH_DATA;
        end
        PH_ADDR: ph <= PH_DATA;
        PH_DATA: begin
          if (!write_q) begin
            if (is8) begin
              if (hi_q) rdata_q[W-1:B] <= pad_in[B-1:0];
              else      rdata_q[B-1:0] <= pad_in[B-1:0];
            end else if (word_q) begin
              rdata_q <= pad_in;
            end else begin
              rdata_q[B-1:0] <= pad_in[B-1:0];
            end
          end
          if (is8 && word_q && !hi_q) begin
            hi_q <= 1'b1;
            ph   <= mux ? PH_ADDR : PH_DATA;
          end else begin
            ph <= PH_DONE;
          end
        end
        default: if (rsp_ready) ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    alt_out = '0;
    alt_oe  = '0;
    case (ph)
      PH_ADDR: begin
        alt_out = cur_addr;
        alt_oe  = '1;
      end
      PH_DATA: begin
        if (is8) begin
          alt_out = {cur_addr[W-1:B], byte_sel};
          if (mux)     alt_oe[W-1:B] = '1;
          if (write_q) alt_oe[B-1:0] = '1;
        end else begin
          alt_out = wdata_q;
          if (write_q) alt_oe = '1;
        end
      end
      default: ;
    endcase
  end

  // R2: an address clock is always followed by a data clock
  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ADDR) |=> (ph == PH_DATA));

  // R9: a stalled response holds its data
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/adport_lane.sv
module adport_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own,
  input  logic              drive_en,
  input  logic              dir_we,
  input  logic [LANE_W-1:0] dir_wd,
  input  logic              lat_we,
  input  logic [LANE_W-1:0] lat_wd,
  input  logic [LANE_W-1:0] alt_out,
  input  logic [LANE_W-1:0] alt_oe,
  output logic [LANE_W-1:0] pad_o,
  output logic [LANE_W-1:0] pad_oe
);
  logic [LANE_W-1:0] dir_q, lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_we)         dir_q <= dir_wd;
      if (lat_we && !own) lat_q <= lat_wd;
    end
  end

  assign pad_o  = own ? alt_out : lat_q;
  assign pad_oe = !drive_en ? '0 : (own ? alt_oe : dir_q);
endmodule

// File: rtl/adport_ctrl.sv
module adport_ctrl
  import adport_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  output logic [LANE_W-1:0] cfg_o,
  output logic              pullup_en,
  input  logic              sw_dir_we,
  input  logic [PORT_W-1:0] sw_dir_wd,
  input  logic              sw_out_we,
  input  logic [PORT_W-1:0] sw_out_wd,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [PORT_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PORT_W-1:0] rsp_rdata,
  input  logic [PORT_W-1:0] pad_i,
  output logic [PORT_W-1:0] pad_o,
  output logic [PORT_W-1:0] pad_oe
);
  localparam int LANES = PORT_W / LANE_W;

  logic              cfg_valid, bus_on, seq_write;
  bus_mode_e         mode;
  phase_e            seq_phase;
  logic [PORT_W-1:0] alt_out, alt_oe;

  adport_cfg #(.CFG_W(LANE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .pad_hi(pad_i[PORT_W-1:PORT_W-LANE_W]),
    .cfg_o(cfg_o), .cfg_valid(cfg_valid)
  );

  assign mode      = bus_mode_e'(cfg_o[1:0]);
  assign bus_on    = bus_en && cfg_valid;
  assign pullup_en = !cfg_valid;

  adport_seq #(.W(PORT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(bus_on), .mode(mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_i), .alt_out(alt_out), .alt_oe(alt_oe),
    .phase_o(seq_phase), .write_o(seq_write)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic own;
    assign own = bus_on && ((g == 0) || (mode != MODE_DMX8));
    adport_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .own(own), .drive_en(cfg_valid),
      .dir_we(sw_dir_we), .dir_wd(sw_dir_wd[g*LANE_W +: LANE_W]),
      .lat_we(sw_out_we), .lat_wd(sw_out_wd[g*LANE_W +: LANE_W]),
      .alt_out(alt_out[g*LANE_W +: LANE_W]), .alt_oe(alt_oe[g*LANE_W +: LANE_W]),
      .pad_o(pad_o[g*LANE_W +: LANE_W]), .pad_oe(pad_oe[g*LANE_W +: LANE_W])
    );
  end

  // R1: no pin is driven while pull-ups are requested
  assert_quiet_pullup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en |-> (pad_oe == '0));

  // R3: the low lane is released in a read data clock
  assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_phase == PH_DATA) && !seq_write) |-> (pad_oe[LANE_W-1:0] == '0));

  // R6: in 8-bit multiplexed mode the upper address byte is held from the address clock
  assert_hi_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_phase == PH_DATA) && (mode == MODE_MUX8)) |->
      ($stable(pad_o[PORT_W-1:LANE_W]) && (&pad_oe[PORT_W-1:LANE_W])));
endmodule

// File: tb/tb_adport_ctrl.sv
module tb_adport_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic [7:0]  cfg_o;
  logic        pullup_en;
  logic        sw_dir_we = 1'b0, sw_out_we = 1'b0;
  logic [15:0] sw_dir_wd = '0, sw_out_wd = '0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_rdata, pad_i = '0, pad_o, pad_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] bm;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  adport_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cfg_o(cfg_o), .pullup_en(pullup_en),
    .sw_dir_we(sw_dir_we), .sw_dir_wd(sw_dir_wd), .sw_out_we(sw_out_we), .sw_out_wd(sw_out_wd),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a response is handed over
  initial forever begin
    @(negedge clk);
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
      else check("R9 response data", 32'(rsp_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic do_reset(input logic [7:0] cfg);
    rst_n = 1'b0;
    bus_en = 1'b0;
    pad_i = {cfg, 8'h00};
    repeat (3) @(negedge clk);
    check("R1 pullup in reset", 32'(pullup_en), 32'd1);
    check("R1 pins quiet in reset", 32'(pad_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg captured", 32'(cfg_o), 32'(cfg));
    check("R1 pullup off", 32'(pullup_en), 32'd0);
    bm = cfg[1:0];
  endtask

  task automatic sw_write(input bit is_dir, input logic [15:0] v);
    if (is_dir) begin sw_dir_we = 1'b1; sw_dir_wd = v; end
    else        begin sw_out_we = 1'b1; sw_out_wd = v; end
    @(negedge clk);
    sw_dir_we = 1'b0;
    sw_out_we = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input bit wr, input bit wd,
                        input logic [15:0] wdat, input logic [7:0] r0, input logic [7:0] r1);
    bit is8, mux;
    int n;
    logic [15:0] ca;
    logic [7:0] bv;
    is8 = (bm[1] == 1'b0);
    mux = bm[0];
    n = (is8 && wd) ? 2 : 1;
    exp_q.push_back(wr ? 16'h0 : (wd ? {r1, r0} : {8'h00, r0}));
    check("R8 ready before request", 32'(req_ready), 32'd1);
    req_addr = a; req_write = wr; req_word = wd; req_wdata = wdat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      ca = a + 16'(k);
      if (mux) begin
        check("R2 address on pins", 32'(pad_o), 32'(ca));
        check("R2 address enables", 32'(pad_oe), 32'hFFFF);
        @(negedge clk);
      end
      pad_i = is8 ? {8'hA5, (k == 1) ? r1 : r0} : {r1, r0};
      if (bm == 2'b01) begin
        check("R6 high byte address", 32'(pad_o[15:8]), 32'(ca[15:8]));
        check("R6 high byte enabled", 32'(pad_oe[15:8]), 32'hFF);
      end
      if (!wr) begin
        check("R3 low lane released", 32'(pad_oe[7:0]), 32'h0);
      end else if (is8) begin
        bv = (k == 1) ? wdat[15:8] : wdat[7:0];
        check("R4 R5 write byte", 32'(pad_o[7:0]), 32'(bv));
        check("R4 write byte enabled", 32'(pad_oe[7:0]), 32'hFF);
      end else begin
        check("R4 write word", 32'(pad_o), 32'(wdat));
        check("R4 write word enabled", 32'(pad_oe), 32'hFFFF);
      end
      @(negedge clk);
    end
    check("R9 response raised", 32'(rsp_valid), 32'd1);
    if (rsp_ready) @(negedge clk);
  endtask

  initial begin
    // 8-bit multiplexed
    do_reset(8'hF1);
    sw_write(1'b1, 16'h00FF);
    sw_write(1'b0, 16'h1234);
    check("R11 gp direction", 32'(pad_oe), 32'h00FF);
    check("R11 gp latch", 32'(pad_o), 32'h1234);
    check("R8 not ready in gp mode", 32'(req_ready), 32'd0);
    bus_en = 1'b1;
    @(negedge clk);
    access(16'h40FF, 1'b0, 1'b1, 16'h0, 8'h3C, 8'hC3);   // R5 two byte cycles, carry into high byte
    access(16'h2000, 1'b1, 1'b1, 16'hBEEF, 8'h0, 8'h0);
    sw_write(1'b0, 16'hFFFF);                            // R10 discarded
    sw_write(1'b1, 16'hF0F0);
    check("R8 idle ready", 32'(req_ready), 32'd1);
    bus_en = 1'b0;
    @(negedge clk);
    check("R11 direction from bus period", 32'(pad_oe), 32'hF0F0);
    check("R10 latch unchanged", 32'(pad_o), 32'h1234);

    // 8-bit demultiplexed
    do_reset(8'h00);
    sw_write(1'b1, 16'hFF00);
    sw_write(1'b0, 16'hAB00);
    bus_en = 1'b1;
    @(negedge clk);
    access(16'h0010, 1'b0, 1'b0, 16'h0, 8'h5A, 8'h00);
    check("R7 high lane software dir", 32'(pad_oe[15:8]), 32'hFF);
    check("R7 high lane software value", 32'(pad_o[15:8]), 32'hAB);
    access(16'h0020, 1'b1, 1'b1, 16'h1357, 8'h0, 8'h0);
    sw_write(1'b0, 16'hCDEF);
    check("R10 software lane write taken", 32'(pad_o[15:8]), 32'hCD);
    bus_en = 1'b0;
    @(negedge clk);
    check("R10 bus lane write discarded", 32'(pad_o), 32'hCD00);

    // 16-bit demultiplexed, with response back-pressure
    do_reset(8'h02);
    bus_en = 1'b1;
    @(negedge clk);
    access(16'h0100, 1'b0, 1'b0, 16'h0, 8'hAA, 8'h77);
    rsp_ready = 1'b0;
    access(16'h0200, 1'b0, 1'b1, 16'h0, 8'h01, 8'h80);
    check("R8 busy while response pending", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R9 response held", 32'(rsp_valid), 32'd1);
    check("R9 data held", 32'(rsp_rdata), 32'h8001);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 response consumed", 32'(rsp_valid), 32'd0);
    access(16'h0300, 1'b1, 1'b0, 16'h4321, 8'h0, 8'h0);

    // 16-bit multiplexed
    do_reset(8'h03);
    bus_en = 1'b1;
    @(negedge clk);
    access(16'h0F0F, 1'b1, 1'b1, 16'hA55A, 8'h0, 8'h0);
    access(16'h9999, 1'b0, 1'b1, 16'h0, 8'h34, 8'h12);
    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule